// File: doc/BRIEF.md
# DRAM Read Strobe Sequencer

This block generates the row and column address strobes for a single DRAM read. While idle it holds both active-low strobes high and raises its ready flag. When a request is seen with ready high, it pulls the row strobe low at the next clock edge. It then steps through three phases: a row-only phase, a short phase in which both strobes are low, and a precharge phase in which both are high again. After precharge it spends one cycle idle before it can accept the next request. Every phase lasts a whole number of clocks. With the default lengths (4, 1 and 2 cycles) and a 20 ns clock, the row strobe is low for 100 ns, the column strobe for 20 ns, and precharge lasts 40 ns. One read therefore takes 7 cycles, or 140 ns, which covers a part with an 85 ns row pulse, a 20 ns column pulse, a 35 ns precharge and a 120 ns cycle.

The request is a plain level input and the ready flag tells the requester when a request will be taken. There is no data path. A request held high is taken once per idle cycle, so a held request gives back-to-back reads spaced 8 cycles apart.

Each output comes straight from its own flip-flop. That flip-flop is loaded from the next-state value, so the strobes cannot glitch and still change in the same edge as the state they belong to. The phase register uses one-hot codes. Any code that is not one of the four legal ones returns the machine to idle.

Top module: `dram_rd_seq`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `ras_n_o` = 1, `cas_n_o` = 1 and `rdy_o` = 1 immediately, without waiting for a clock edge.
- R2: In idle with `req_i` low, the outputs stay at `ras_n_o` = 1, `cas_n_o` = 1, `rdy_o` = 1.
- R3: If `req_i` is sampled 1 at a rising edge while the machine is idle, then after that same edge `ras_n_o` = 0 and `rdy_o` = 0.
- R4: For each accepted request, `ras_n_o` stays low for exactly ROW_CYC+COL_CYC consecutive cycles (5 with the defaults).
- R5: `cas_n_o` is low for exactly COL_CYC cycles (1 with the defaults), in the last cycles of the row-strobe pulse, and is never low while `ras_n_o` is high.
- R6: After the row strobe rises, both strobes stay high with `rdy_o` = 0 for PRE_CYC cycles (2 with the defaults). Then `rdy_o` = 1 for at least one idle cycle. One read lasts ROW_CYC+COL_CYC+PRE_CYC cycles (7).
- R7: `req_i` has no effect while `rdy_o` = 0. The output sequence is the same whatever `req_i` does during a read.
- R8: If `req_i` is held high, the next row-strobe fall comes exactly PRE_CYC+1 cycles after the row strobe rises, so reads start every 8 cycles.
- R9: A phase-register value that is not one of the four one-hot codes (idle 0001, row 0010, both 0100, precharge 1000) moves the machine to idle at the next edge, with both strobes high and `rdy_o` = 1. It does not start a read at that edge, even if `req_i` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request, sampled only while `rdy_o` is high |
| rdy_o | output | 1 | High while idle, when a request will be accepted |
| ras_n_o | output | 1 | Row address strobe, active low, registered |
| cas_n_o | output | 1 | Column address strobe, active low, registered |

## Verification
The hardest case to reach is an illegal phase code. No sequence on the ports can produce one, so the bench forces a corrupt code into the phase register for a single cycle while the machine is idle and the request is already high. The expected recovery is visible at the ports: one more idle cycle with the strobes high, and only after that the start of a read. Random request patterns with a fixed seed, including requests toggled during reads and held across them, cover the ignore rule and back-to-back spacing. An asynchronous reset in the middle of a read checks that the strobes are released at once.

// File: rtl/dram_rd_seq_pkg.sv
`timescale 1ns/1ps
package dram_rd_seq_pkg;

  // One-hot phase codes; any other value is treated as corrupt.
  typedef enum logic [3:0] {
    PH_IDLE = 4'b0001,
    PH_ROW  = 4'b0010,
    PH_COL  = 4'b0100,
    PH_PRE  = 4'b1000
  } phase_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic rdy;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, rdy: 1'b1};

  // Output pattern that belongs to a phase.
  function automatic strobe_t strobes_for(input phase_e ph);
    strobe_t s;
    case (ph)
      PH_ROW:  s = '{ras_n: 1'b0, cas_n: 1'b1, rdy: 1'b0};
      PH_COL:  s = '{ras_n: 1'b0, cas_n: 1'b0, rdy: 1'b0};
      PH_PRE:  s = '{ras_n: 1'b1, cas_n: 1'b1, rdy: 1'b0};
      default: s = STROBE_IDLE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dram_rd_seq_timer.sv
`timescale 1ns/1ps
module dram_rd_seq_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/dram_rd_seq_fsm.sv
`timescale 1ns/1ps
module dram_rd_seq_fsm
  import dram_rd_seq_pkg::*;
#(
  parameter int ROW_CYC = 4,
  parameter int COL_CYC = 1,
  parameter int PRE_CYC = 2,
  parameter int CW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          zero,
  output phase_e        st_q,
  output phase_e        st_d,
  output logic          load,
  output logic [CW-1:0] load_val
);

  localparam logic [CW-1:0] ROW_LAST = CW'(ROW_CYC - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(COL_CYC - 1);
  localparam logic [CW-1:0] PRE_LAST = CW'(PRE_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PH_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    st_d     = st_q;
    load     = 1'b0;
    load_val = '0;
    case (st_q)
      PH_IDLE: if (req) begin
        st_d = PH_ROW; load = 1'b1; load_val = ROW_LAST;
      end
      PH_ROW: if (zero) begin
        st_d = PH_COL; load = 1'b1; load_val = COL_LAST;
      end
      PH_COL: if (zero) begin
        st_d = PH_PRE; load = 1'b1; load_val = PRE_LAST;
      end
      PH_PRE: if (zero) st_d = PH_IDLE;
      default: st_d = PH_IDLE;   // corrupt code: recover to idle
    endcase
  end

endmodule

// File: rtl/dram_rd_seq_outreg.sv
`timescale 1ns/1ps
module dram_rd_seq_outreg
  import dram_rd_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e st_d,
  output logic   ras_n,
  output logic   cas_n,
  output logic   rdy
);

  strobe_t nxt, out_q;

  assign nxt = strobes_for(st_d);

  // Look-ahead: registering the pattern of the next phase keeps the
  // outputs glitch-free without adding a cycle of latency.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= STROBE_IDLE;
    else        out_q <= nxt;
  end

  assign ras_n = out_q.ras_n;
  assign cas_n = out_q.cas_n;
  assign rdy   = out_q.rdy;

endmodule

// File: rtl/dram_rd_seq.sv
`timescale 1ns/1ps
module dram_rd_seq
  import dram_rd_seq_pkg::*;
#(
  parameter int ROW_CYC = 4,
  parameter int COL_CYC = 1,
  parameter int PRE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic rdy_o,
  output logic ras_n_o,
  output logic cas_n_o
);

  localparam int MAXLEN = (ROW_CYC > COL_CYC) ?
                          ((ROW_CYC > PRE_CYC) ? ROW_CYC : PRE_CYC) :
                          ((COL_CYC > PRE_CYC) ? COL_CYC : PRE_CYC);
  localparam int CW = (MAXLEN > 1) ? $clog2(MAXLEN) : 1;

  phase_e          st_q, st_d;
  logic            load, zero;
  logic [CW-1:0]   load_val;

  dram_rd_seq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .zero(zero)
  );

  dram_rd_seq_fsm #(
    .ROW_CYC(ROW_CYC), .COL_CYC(COL_CYC), .PRE_CYC(PRE_CYC), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req_i), .zero(zero),
    .st_q(st_q), .st_d(st_d), .load(load), .load_val(load_val)
  );

  dram_rd_seq_outreg u_out (
    .clk(clk), .rst_n(rst_n), .st_d(st_d),
    .ras_n(ras_n_o), .cas_n(cas_n_o), .rdy(rdy_o)
  );

endmodule

// File: rtl/dram_rd_seq_chk.sv
`timescale 1ns/1ps
module dram_rd_seq_chk #(
  parameter int ROW_CYC = 4,
  parameter int COL_CYC = 1,
  parameter int PRE_CYC = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_i,
  input logic       rdy_o,
  input logic       ras_n_o,
  input logic       cas_n_o,
  input logic [3:0] st
);

  localparam int CAP = ROW_CYC + COL_CYC + PRE_CYC + 2;
  localparam int KW  = $clog2(CAP + 1);

  logic [KW-1:0] ras_lo, cas_lo, ras_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_lo <= '0;
      cas_lo <= '0;
      ras_hi <= KW'(CAP);
    end else begin
      ras_lo <= ras_n_o ? '0 : ((ras_lo == KW'(CAP)) ? ras_lo : ras_lo + 1'b1);
      cas_lo <= cas_n_o ? '0 : ((cas_lo == KW'(CAP)) ? cas_lo : cas_lo + 1'b1);
      ras_hi <= !ras_n_o ? '0 : ((ras_hi == KW'(CAP)) ? ras_hi : ras_hi + 1'b1);
    end
  end

  AST_READY_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |-> (ras_n_o && cas_n_o)); // R2

  AST_ACCEPT_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'b0001 && req_i) |=> (!ras_n_o && !rdy_o)); // R3

  AST_RAS_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n_o) |-> (ras_lo >= KW'(ROW_CYC + COL_CYC))); // R4

  AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n_o |-> !ras_n_o); // R5

  AST_CAS_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n_o) |-> (cas_lo >= KW'(COL_CYC))); // R5

  AST_PRE_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> (ras_hi >= KW'(PRE_CYC + 1))); // R6

  AST_BAD_CODE_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(st) != 1) |=> (rdy_o && ras_n_o && cas_n_o)); // R9

endmodule

bind dram_rd_seq dram_rd_seq_chk #(
  .ROW_CYC(ROW_CYC), .COL_CYC(COL_CYC), .PRE_CYC(PRE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .rdy_o(rdy_o),
  .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .st(st_q)
);

// File: tb/dram_rd_seq_tb_top.sv
`timescale 1ns/1ps
module dram_rd_seq_tb_top;

  localparam int ROW = 4, COL = 1, PRE = 2;
  localparam int RD  = ROW + COL + PRE;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic rdy, ras_n, cas_n;

  int   n_chk = 0, n_bad = 0;
  int   mpos = 0;          // 0 idle, 1..RD position in the read
  bit   inj = 1'b0;
  bit   done = 1'b0;
  string tag = "";

  always #2.5 clk = ~clk;

  dram_rd_seq #(.ROW_CYC(ROW), .COL_CYC(COL), .PRE_CYC(PRE)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req),
    .rdy_o(rdy), .ras_n_o(ras_n), .cas_n_o(cas_n)
  );

  function automatic logic exp_ras_n(int p); return !(p >= 1 && p <= ROW + COL); endfunction
  function automatic logic exp_cas_n(int p); return !(p > ROW && p <= ROW + COL); endfunction
  function automatic logic exp_rdy(int p);   return (p == 0); endfunction

  function automatic string auto_tag(int p);
    if (p == 0)         return "R2";
    if (p <= ROW + COL) return "R4";
    return "R6";
  endfunction

  task automatic check(input logic act, input logic exp, input string t, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b pos=%0d t=%0t", t, what, act, exp, mpos, $time);
    end
  endtask

  task automatic compare_all();
    string t;
    t = (tag != "") ? tag : auto_tag(mpos);
    check(ras_n, exp_ras_n(mpos), t, "ras_n");
    check(cas_n, exp_cas_n(mpos), (mpos > ROW) ? "R5" : t, "cas_n");
    check(rdy,   exp_rdy(mpos),   t, "rdy");
  endtask

  // Drive req, take one edge, advance the model, sample at the falling edge.
  task automatic step(input logic r);
    req = r;
    @(posedge clk);
    if (!rst_n)          mpos = 0;
    else if (inj)        begin mpos = 0; inj = 1'b0; end
    else if (mpos == 0)  mpos = r ? 1 : 0;
    else if (mpos == RD) mpos = 0;
    else                 mpos = mpos + 1;
    @(negedge clk);
    compare_all();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int rs;
    int spacing;
    logic prev_ras;
    rs = $urandom(32'h5eed_0042);

    // R1: reset state
    @(negedge clk);
    tag = "R1"; compare_all();
    repeat (2) step(1'b1);
    rst_n = 1'b1;
    tag = "";
    repeat (3) step(1'b0);                 // R2: idle holds

    // R3/R4/R5/R6: one directed read
    tag = "R3"; step(1'b1);
    tag = "";
    repeat (RD + 2) step(1'b0);

    // R7: request toggles during a read are ignored
    step(1'b1);
    tag = "R7";
    for (int i = 0; i < RD - 1; i++) step(i[0]);
    tag = "";
    repeat (2) step(1'b0);

    // R8: held request gives reads every RD+1 cycles
    spacing = 0; prev_ras = ras_n;
    tag = "R8";
    for (int i = 0; i < 3 * (RD + 1); i++) begin
      step(1'b1);
      if (prev_ras && !ras_n) begin
        if (spacing != 0) check(spacing == RD + 1, 1'b1, "R8", "read spacing");
        spacing = 0;
      end
      spacing++;
      prev_ras = ras_n;
    end
    tag = "";
    repeat (RD + 2) step(1'b0);

    // R9: corrupt phase code while idle with req high
    force dut_i.u_fsm.st_q = dram_rd_seq_pkg::phase_e'(4'b0110);
    #1 release dut_i.u_fsm.st_q;
    inj = 1'b1;
    tag = "R9"; step(1'b1);
    tag = "R3"; step(1'b1);
    tag = "";
    repeat (RD + 2) step(1'b0);

    // R1: asynchronous reset in the middle of a read
    step(1'b1); step(1'b0); step(1'b0);
    rst_n = 1'b0; #1;
    mpos = 0; tag = "R1"; compare_all();
    step(1'b1);
    rst_n = 1'b1;
    tag = "";

    // Random request patterns (R2-R7)
    for (int i = 0; i < 2000; i++) begin
      int k;
      k = $urandom_range(0, 3);
      step(k != 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule